// File: doc/BRIEF.md
# Watchdog Timer with Clock-Domain-Crossing Configuration

This block is an independent watchdog timer. Its down-counter runs on a slow, low-power clock. Software programs it through a small register interface clocked by the bus clock. There are four word registers, selected by `bus_addr`:

| Address | Contents |
|---------|----------|
| 0x0 | command key |
| 0x4 | 3-bit divider select |
| 0x8 | 12-bit reload value |
| 0xC | status |

The divider and reload registers are write-protected. An accepted write to either one is held in a bus-side staging register. It is then handed to the slow domain with a toggle handshake. While the handover is in flight, a per-field busy flag in the status register is set. That flag blocks further writes to the field and marks the readback as stale.

Command keys written to address 0x0 control the block:

| Key | Effect |
|-----|--------|
| 0x5555 | lifts the write protection |
| 0xCCCC | starts the counter |
| 0xAAAA | reloads the counter (refresh) |
| any other value | restores the write protection |

Once the counter is running, it steps down once per divided tick. When it reaches zero it emits a one-cycle reset request in the slow domain and reloads itself.

Top module: `wdg_xdomain`

## Requirements
- R1: After reset, the reload register (0x8) reads 0xFFF, the divider register (0x4) and status register (0xC) read 0, and `wdg_rst_req` is low.
- R2: The reload value is held in bits 11:0 of address 0x8. Bits 31:12 ignore writes and read as zero.
- R3: Writing key 0x5555 to address 0x0 lifts the write protection, and any other key value restores it. While the protection is in force, writes to 0x4 and 0x8 are ignored.
- R4: An accepted write sets the busy flag of its field in the status register on the next bus cycle. Bit 1 is the reload flag and bit 0 is the divider flag. Status bits 31:2 read as zero.
- R5: A busy flag clears without further bus activity within 5 slow-clock periods of the write. The field then reads back the new value.
- R6: A write to a field whose busy flag is set is ignored, and the earlier value is the one applied.
- R7: Key 0xCCCC starts the watchdog, and no reset request appears before it is started. After the start, no key value stops it; only reset does.
- R8: Key 0xAAAA loads the counter with the reload value. Refreshing more often than the timeout period prevents any reset request.
- R9: The divider select PR gives a slow-clock divide of 4<<PR for PR 0 to 6, and 256 for PR 7. Consecutive reset requests are max(reload,1)*divide slow cycles apart.
- R10: `wdg_rst_req` is a pulse one slow-clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register interface clock |
| lp_clk | input | 1 | Slow counter clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| bus_we | input | 1 | Write strobe, sampled on bus_clk |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdg_rst_req | output | 1 | Timeout reset request pulse, lp_clk domain |

## Verification
The assertions assume three things about the environment. The bus issues at most one write per bus cycle, with stable address and data around the edge. `rst_n` is asserted at time zero. The slow clock is several times slower than the bus clock, so the handshake settles within the stated bound. The bench keeps within these assumptions in four ways. It drives writes on the falling bus edge. It keeps the period ratio fixed. It draws random divider settings from 0 to 2 and reload values from 0 to 20, so that every timeout stays short. It waits for the busy flags to clear before it issues each refresh key.

// File: rtl/wdg_xdomain.sv
module wdg_xdomain #(
  parameter int RLW = 12,
  parameter int PRW = 3,
  parameter int DW  = 32,
  parameter int AW  = 4,
  parameter logic [RLW-1:0] RL_RST = '1
) (
  input  logic          bus_clk,
  input  logic          lp_clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wdg_rst_req
);
  localparam logic [15:0] K_UNLOCK = 16'h5555;
  localparam logic [15:0] K_KICK   = 16'hAAAA;
  localparam logic [15:0] K_START  = 16'hCCCC;
  localparam int PREW = 8;

  logic           unlocked;
  logic [RLW-1:0] rl_stage, rl_lp;
  logic [PRW-1:0] pr_stage, pr_lp;
  logic           rl_req, pr_req, kick_tgl, start_tgl;
  logic [1:0]     rl_ack_s, pr_ack_s;
  logic [2:0]     rl_req_s, pr_req_s, kick_s, start_s;
  logic           rl_ack, pr_ack, running;
  logic [RLW-1:0] cnt;
  logic [PREW-1:0] pre, div_m1;

  wire busy_rl = rl_req != rl_ack_s[1];
  wire busy_pr = pr_req != pr_ack_s[1];
  wire key_wr  = bus_we && bus_addr == AW'(0);
  wire rl_wr   = bus_we && bus_addr == AW'(8) && unlocked && !busy_rl;
  wire pr_wr   = bus_we && bus_addr == AW'(4) && unlocked && !busy_pr;
  wire unused_ok = &{1'b0, bus_wdata[DW-1:16]};

  always_ff @(posedge bus_clk or negedge rst_n)
    if (!rst_n) begin
      unlocked  <= 1'b0;
      rl_stage  <= RL_RST;
      pr_stage  <= '0;
      rl_req    <= 1'b0;
      pr_req    <= 1'b0;
      kick_tgl  <= 1'b0;
      start_tgl <= 1'b0;
      rl_ack_s  <= '0;
      pr_ack_s  <= '0;
    end else begin
      rl_ack_s <= {rl_ack_s[0], rl_ack};
      pr_ack_s <= {pr_ack_s[0], pr_ack};
      if (key_wr) begin
        unlocked <= bus_wdata[15:0] == K_UNLOCK;
        if (bus_wdata[15:0] == K_KICK)  kick_tgl  <= ~kick_tgl;
        if (bus_wdata[15:0] == K_START) start_tgl <= ~start_tgl;
      end
      if (rl_wr) begin
        rl_stage <= bus_wdata[RLW-1:0];
        rl_req   <= ~rl_req;
      end
      if (pr_wr) begin
        pr_stage <= bus_wdata[PRW-1:0];
        pr_req   <= ~pr_req;
      end
    end

  always_comb
    case (bus_addr)
      AW'(4):  bus_rdata = DW'(pr_lp);
      AW'(8):  bus_rdata = DW'(rl_lp);
      AW'(12): bus_rdata = DW'({busy_rl, busy_pr});
      default: bus_rdata = '0;
    endcase

  wire kick_ev  = kick_s[1]  != kick_s[2];
  wire start_ev = start_s[1] != start_s[2];
  assign div_m1 = (pr_lp == '1) ? '1 : PREW'((9'd4 << pr_lp) - 9'd1);
  wire tick = running && pre >= div_m1;

  always_ff @(posedge lp_clk or negedge rst_n)
    if (!rst_n) begin
      rl_req_s    <= '0;
      pr_req_s    <= '0;
      kick_s      <= '0;
      start_s     <= '0;
      rl_ack      <= 1'b0;
      pr_ack      <= 1'b0;
      rl_lp       <= RL_RST;
      pr_lp       <= '0;
      running     <= 1'b0;
      cnt         <= RL_RST;
      pre         <= '0;
      wdg_rst_req <= 1'b0;
    end else begin
      rl_req_s    <= {rl_req_s[1:0], rl_req};
      pr_req_s    <= {pr_req_s[1:0], pr_req};
      kick_s      <= {kick_s[1:0], kick_tgl};
      start_s     <= {start_s[1:0], start_tgl};
      wdg_rst_req <= 1'b0;
      if (rl_req_s[1] != rl_ack) begin
        rl_lp  <= rl_stage;
        rl_ack <= rl_req_s[1];
      end
      if (pr_req_s[1] != pr_ack) begin
        pr_lp  <= pr_stage;
        pr_ack <= pr_req_s[1];
      end
      if (start_ev) running <= 1'b1;
      if (start_ev || kick_ev) begin
        cnt <= rl_lp;
        pre <= '0;
      end else if (tick) begin
        pre <= '0;
        if (cnt <= RLW'(1)) begin
          cnt         <= rl_lp;
          wdg_rst_req <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (running) begin
        pre <= pre + 1'b1;
      end
    end
endmodule

// File: rtl/wdg_xdomain_chk.sv
module wdg_xdomain_chk #(
  parameter int RLW = 12,
  parameter int AW  = 4
) (
  input logic           bus_clk,
  input logic           lp_clk,
  input logic           rst_n,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic           unlocked,
  input logic           busy_rl,
  input logic           busy_pr,
  input logic [RLW-1:0] rl_stage,
  input logic           running,
  input logic           wdg_rst_req
);
  wire wr_rl = bus_we && bus_addr == AW'(8);
  wire wr_pr = bus_we && bus_addr == AW'(4);

  AST_LOCK_RL:    assert property (@(posedge bus_clk) disable iff (!rst_n) !unlocked && wr_rl |=> $stable(rl_stage)); // R3
  AST_BUSY_HOLD:  assert property (@(posedge bus_clk) disable iff (!rst_n) busy_rl && wr_rl |=> $stable(rl_stage)); // R6
  AST_RL_BUSY:    assert property (@(posedge bus_clk) disable iff (!rst_n) unlocked && !busy_rl && wr_rl |=> busy_rl); // R4
  AST_PR_BUSY:    assert property (@(posedge bus_clk) disable iff (!rst_n) unlocked && !busy_pr && wr_pr |=> busy_pr); // R4
  AST_PULSE_ONE:  assert property (@(posedge lp_clk) disable iff (!rst_n) wdg_rst_req |=> !wdg_rst_req); // R10
  AST_RUN_STICKY: assert property (@(posedge lp_clk) disable iff (!rst_n) running |=> running); // R7
  AST_IDLE_QUIET: assert property (@(posedge lp_clk) disable iff (!rst_n) !running |-> !wdg_rst_req); // R7
endmodule

bind wdg_xdomain wdg_xdomain_chk #(.RLW(RLW), .AW(AW)) u_chk (
  .bus_clk(bus_clk), .lp_clk(lp_clk), .rst_n(rst_n), .bus_we(bus_we),
  .bus_addr(bus_addr), .unlocked(unlocked), .busy_rl(busy_rl),
  .busy_pr(busy_pr), .rl_stage(rl_stage), .running(running),
  .wdg_rst_req(wdg_rst_req)
);

// File: tb/wdg_xdomain_tb.sv
module wdg_xdomain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LP_PERIOD  = 30;

  logic        bus_clk = 0, lp_clk = 0, rst_n = 0, bus_we = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        wdg_rst_req;

  int checks = 0, errors = 0;
  int lp_cyc = 0, pulse_cnt = 0, pulse_t = 0, hi_run = 0, max_w = 0;

  wdg_xdomain u_dut (.*);

  always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
  always #(LP_PERIOD/2)  lp_clk  = ~lp_clk;
  always @(posedge lp_clk) lp_cyc++;
  always @(negedge lp_clk)
    if (wdg_rst_req) begin
      if (hi_run == 0) begin pulse_cnt++; pulse_t = lp_cyc; end
      hi_run++;
      if (hi_run > max_w) max_w = hi_run;
    end else hi_run = 0;

  function automatic int exp_period(int pr, int rl);
    int d = (pr == 7) ? 256 : (4 << pr);
    return ((rl < 1) ? 1 : rl) * d;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [3:0] a, logic [31:0] d);
    @(negedge bus_clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk); bus_we = 0;
  endtask

  task automatic bread(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] s;
    n = 0;
    bread(4'hC, s);
    while (s != 0 && n < 100) begin
      @(negedge bus_clk); n++; bread(4'hC, s);
    end
  endtask

  task automatic wait_pulse(int limit, output int t, output bit ok);
    int n0 = pulse_cnt;
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge lp_clk); #1;
      if (pulse_cnt > n0) begin ok = 1; break; end
    end
    t = pulse_t;
  endtask

  task automatic cfg(int pr, int rl);
    int n;
    bwrite(4'h0, 32'h5555);
    bwrite(4'h4, pr);
    bwrite(4'h8, rl);
    wait_idle(n);
    bwrite(4'h0, 32'hAAAA);
  endtask

  task automatic measure(string req, int pr, int rl);
    int t1, t2, t3; bit ok1, ok2, ok3;
    int p = exp_period(pr, rl);
    cfg(pr, rl);
    wait_pulse(30000, t1, ok1);
    wait_pulse(p + 20, t2, ok2);
    wait_pulse(p + 20, t3, ok3);
    chk(req, ok1 && ok2 && ok3, 1);
    chk(req, t3 - t2, p);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d; int n, t; bit ok, gotp;
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3 + 1); rst_n = 1;
    @(negedge bus_clk);
    bread(4'h8, d); chk("R1 reload", d, 32'hFFF);
    bread(4'h4, d); chk("R1 divider", d, 0);
    bread(4'hC, d); chk("R1 status", d, 0);
    chk("R1 req", wdg_rst_req, 0);

    bwrite(4'h8, 32'h0AB);
    bread(4'hC, d); chk("R3 locked status", d, 0);
    repeat (20) @(negedge bus_clk);
    bread(4'h8, d); chk("R3 locked reload", d, 32'hFFF);

    bwrite(4'h0, 32'h5555);
    bwrite(4'h8, 32'hFFFF_F005);
    bread(4'hC, d); chk("R4 reload busy", d, 32'h2);
    wait_idle(n); chk("R5 busy clears", n <= (5 * LP_PERIOD) / CLK_PERIOD, 1);
    bread(4'h8, d); chk("R2 reload field", d, 32'h005);

    bwrite(4'h8, 32'h00A);
    bwrite(4'h8, 32'h00B);
    wait_idle(n);
    bread(4'h8, d); chk("R6 busy write ignored", d, 32'h00A);

    bwrite(4'h4, 32'h2);
    bread(4'hC, d); chk("R4 divider busy", d, 32'h1);
    wait_idle(n); chk("R5 divider clears", n <= (5 * LP_PERIOD) / CLK_PERIOD, 1);
    bread(4'h4, d); chk("R5 divider readback", d, 32'h2);

    bwrite(4'h0, 32'h1111);
    bwrite(4'h4, 32'h5);
    bread(4'hC, d); chk("R3 relocked status", d, 0);
    repeat (20) @(negedge bus_clk);
    bread(4'h4, d); chk("R3 relocked divider", d, 32'h2);

    cfg(0, 3);
    wait_pulse(300, t, gotp); chk("R7 no request before start", gotp, 0);

    bwrite(4'h0, 32'hCCCC);
    measure("R9 pr0 rl10", 0, 10);

    bwrite(4'h0, 32'h0000);
    bwrite(4'h0, 32'h1234);
    wait_pulse(200, t, ok); chk("R7 not stoppable", ok, 1);

    bwrite(4'h0, 32'hAAAA);
    n = pulse_cnt;
    for (int i = 0; i < 15; i++) begin
      repeat (20) @(negedge lp_clk);
      bwrite(4'h0, 32'hAAAA);
    end
    chk("R8 refresh prevents request", pulse_cnt, n);

    measure("R9 pr7 rl2", 7, 2);
    measure("R9 rl0", 1, 0);

    for (int i = 0; i < 5; i++)
      measure("R9 random", $urandom_range(0, 2), $urandom_range(0, 20));

    chk("R10 pulse width", max_w, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule